// File: doc/BRIEF.md
# Decode Command Buffer Validator

This block inspects a buffer of 32-bit command words that is headed for a video decode engine and decides, before the engine may run it, whether the buffer is safe. The words arrive one per cycle on a valid/ready stream after a start strobe that carries the buffer length and the base address of the engine's firmware segment. The validator walks the packet headers and follows the register writes. When a command register is written, it resolves the referenced buffer through an external relocation lookup and checks the resulting address range.

Every command names a relocation table entry and a byte offset inside it. The checks cover the index, the command code, the minimum buffer size for the code, 256 MB segment rules, and the placement of the single message command. The first violation ends the walk. A one-cycle done pulse then reports the result: a pass flag, or a distinct error code. Both stay on the outputs until the next result.

Top module: `cbv_validator`

## Requirements
- R1: A start with a length that is not a multiple of 16 words is rejected with error 1 on the done pulse one cycle later, and no word is accepted. A length of zero reports error 13.
- R2: Header layout is type in bits 31:30, count in bits 29:16 and register index in bits 15:0. A type-0 header is followed by count+1 words, which write registers index, index+1, and so on. A type-2 packet spans count+2 words in total, and its contents are skipped. Types 1 and 3 give error 2.
- R3: The register indices are 0x0100 (offset), 0x0101 (relocation index), 0x0102 (command) and 0x0103 (engine control, ignored). A write to any other index gives error 3.
- R4: A header whose packet would reach past the buffer length gives error 4. No word beyond the length is ever accepted.
- R5: A command whose latched relocation index is at or above the table length gives error 5.
- R6: The command code is the written value shifted right by one bit. Codes 0 to 3 have minimum sizes of 2048, 33554432, 7077888 and 2048 bytes. Code 0x100 skips the size checks. Any other code gives error 6.
- R7: The start is the relocation base plus the offset, and the end is the base plus the entry size. For codes 0 to 3, an end at or below the start gives error 7, and end minus start below the code's minimum gives error 8.
- R8: A range whose start and end-1 differ in address bits 28 and up gives error 9.
- R9: For codes 0 and 3, a start outside the 256 MB segment of the firmware base gives error 10.
- R10: Code 0 is the message command. A second message gives error 11. Any other command before the message gives error 12. Reaching the end of the buffer without a message gives error 13.
- R11: The done pulse lasts one cycle and follows the error word, or the last word, by one cycle. A clean buffer sets the pass flag with error 0. After done, ready stays low until the next start, and the pass flag and error code are held between results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a new buffer (taken while idle) |
| len_i | input | LEN_W | Buffer length in words |
| seg_base_i | input | ADDR_W | Firmware segment base address |
| reloc_len_i | input | IDX_W+1 | Number of relocation table entries |
| word_valid_i | input | 1 | Command word valid |
| word_i | input | 32 | Command word |
| word_ready_o | output | 1 | Validator accepts a word |
| reloc_idx_o | output | IDX_W | Relocation entry being looked up |
| reloc_base_i | input | ADDR_W | Base address of the looked-up entry |
| reloc_size_i | input | ADDR_W | Size in bytes of the looked-up entry |
| done_o | output | 1 | One-cycle result strobe |
| pass_o | output | 1 | Buffer accepted (held) |
| err_o | output | 4 | Error code of the last result (held) |

## Verification
The assertions check several rules on every cycle. They check the length rejection after a start. They check that no word is taken beyond the announced length. They check that done lasts a single cycle and that ready has dropped when it fires. They check that the result outputs do not change between done pulses. The size, segment, crossing, code and ordering decisions depend on the relocation table contents and on where the command sits in the buffer. Only the directed buffers in the bench can show that each of those rules yields its own error code, and that a clean buffer with padding and control writes passes.

// File: rtl/cbv_pkg.sv
package cbv_pkg;

  typedef enum logic [3:0] {
    E_OK    = 4'd0,
    E_LEN   = 4'd1,
    E_TYPE  = 4'd2,
    E_REG   = 4'd3,
    E_OVR   = 4'd4,
    E_IDX   = 4'd5,
    E_CODE  = 4'd6,
    E_RANGE = 4'd7,
    E_SIZE  = 4'd8,
    E_CROSS = 4'd9,
    E_SEG   = 4'd10,
    E_DUP   = 4'd11,
    E_EARLY = 4'd12,
    E_NOMSG = 4'd13
  } err_e;

  typedef enum logic [1:0] {S_IDLE, S_HDR, S_BODY} state_e;

  localparam logic [1:0]  PKT_REG   = 2'd0;
  localparam logic [1:0]  PKT_PAD   = 2'd2;
  localparam logic [30:0] CODE_FREE = 31'h100;

  function automatic logic [31:0] min_bytes(input logic [1:0] code);
    case (code)
      2'd0:    min_bytes = 32'd2048;
      2'd1:    min_bytes = 32'd32 * 32'd1024 * 32'd1024;
      2'd2:    min_bytes = 32'd2048 * 32'd1152 * 32'd3;
      default: min_bytes = 32'd2048;
    endcase
  endfunction

endpackage

// File: rtl/cbv_operand_regs.sv
module cbv_operand_regs (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clr_i,
  input  logic        lo_we_i,
  input  logic        hi_we_i,
  input  logic [31:0] data_i,
  output logic [31:0] offset_o,
  output logic [31:0] index_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      offset_o <= '0;
      index_o  <= '0;
    end else if (clr_i) begin
      offset_o <= '0;
      index_o  <= '0;
    end else begin
      if (lo_we_i) offset_o <= data_i;
      if (hi_we_i) index_o  <= data_i;
    end
  end
endmodule

// File: rtl/cbv_range_check.sv
module cbv_range_check
  import cbv_pkg::*;
#(
  parameter int ADDR_W  = 40,
  parameter int IDX_W   = 8,
  parameter int SEG_LSB = 28
) (
  input  logic [31:0]       cmd_word_i,
  input  logic [31:0]       offset_i,
  input  logic [31:0]       index_i,
  input  logic [IDX_W:0]    tbl_len_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] size_i,
  input  logic [ADDR_W-1:0] seg_base_i,
  input  logic              msg_seen_i,
  output err_e              err_o,
  output logic              is_msg_o
);
  localparam int AW1 = ADDR_W + 1;

  logic [30:0]    code;
  logic [AW1-1:0] start_a, end_a, last_a, span, need;
  logic           sized, idx_bad, seg_rule;

  assign code     = cmd_word_i[31:1];
  assign sized    = (code < 31'd4);
  assign is_msg_o = (code == 31'd0);
  assign seg_rule = (code == 31'd0) || (code == 31'd3);
  assign idx_bad  = (index_i >= {{(31-IDX_W){1'b0}}, tbl_len_i});
  assign start_a  = {1'b0, base_i} + {{(AW1-32){1'b0}}, offset_i};
  assign end_a    = {1'b0, base_i} + {1'b0, size_i};
  assign last_a   = end_a - 1'b1;
  assign span     = end_a - start_a;
  assign need     = {{(AW1-32){1'b0}}, min_bytes(code[1:0])};

  always_comb begin
    err_o = E_OK;
    if (idx_bad)                                        err_o = E_IDX;
    else if (sized && (end_a <= start_a))               err_o = E_RANGE;
    else if (sized && (span < need))                    err_o = E_SIZE;
    else if (!sized && (code != CODE_FREE))             err_o = E_CODE;
    else if (start_a[AW1-1:SEG_LSB] != last_a[AW1-1:SEG_LSB])
                                                        err_o = E_CROSS;
    else if (seg_rule &&
             (start_a[AW1-1:SEG_LSB] != {1'b0, seg_base_i[ADDR_W-1:SEG_LSB]}))
                                                        err_o = E_SEG;
    else if (is_msg_o && msg_seen_i)                    err_o = E_DUP;
    else if (!is_msg_o && !msg_seen_i)                  err_o = E_EARLY;
  end
endmodule

// File: rtl/cbv_validator.sv
module cbv_validator
  import cbv_pkg::*;
#(
  parameter int          ADDR_W  = 40,
  parameter int          IDX_W   = 8,
  parameter int          LEN_W   = 16,
  parameter int          SEG_LSB = 28,
  parameter logic [15:0] REG_LO  = 16'h0100,
  parameter logic [15:0] REG_HI  = 16'h0101,
  parameter logic [15:0] REG_CMD = 16'h0102,
  parameter logic [15:0] REG_CTL = 16'h0103
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [ADDR_W-1:0] seg_base_i,
  input  logic [IDX_W:0]    reloc_len_i,
  input  logic              word_valid_i,
  input  logic [31:0]       word_i,
  output logic              word_ready_o,
  output logic [IDX_W-1:0]  reloc_idx_o,
  input  logic [ADDR_W-1:0] reloc_base_i,
  input  logic [ADDR_W-1:0] reloc_size_i,
  output logic              done_o,
  output logic              pass_o,
  output logic [3:0]        err_o
);
  localparam int LW1 = LEN_W + 1;

  state_e             st_q, st_d;
  logic [LEN_W-1:0]   len_q, pos_q, pos_d;
  logic [ADDR_W-1:0]  seg_q;
  logic [14:0]        left_q, left_d;
  logic [15:0]        reg_q, reg_d;
  logic               pad_q, pad_d, msg_q, msg_d;
  logic               done_q, pass_q;
  err_e               err_q, fin_err, chk_err;
  logic               fin, acc, clr, lo_we, hi_we, chk_msg;
  logic [31:0]        offset, index;
  logic [1:0]         w_type;
  logic [13:0]        w_cnt;
  logic [LW1-1:0]     need_end;

  assign word_ready_o = (st_q != S_IDLE);
  assign acc          = word_valid_i && word_ready_o;
  assign w_type       = word_i[31:30];
  assign w_cnt        = word_i[29:16];
  assign need_end     = {1'b0, pos_q} + LW1'(w_cnt) + LW1'(2);
  assign reloc_idx_o  = index[IDX_W-1:0];

  cbv_operand_regs u_ops (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr),
    .lo_we_i (lo_we),
    .hi_we_i (hi_we),
    .data_i  (word_i),
    .offset_o(offset),
    .index_o (index)
  );

  cbv_range_check #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .SEG_LSB(SEG_LSB)) u_chk (
    .cmd_word_i(word_i),
    .offset_i  (offset),
    .index_i   (index),
    .tbl_len_i (reloc_len_i),
    .base_i    (reloc_base_i),
    .size_i    (reloc_size_i),
    .seg_base_i(seg_q),
    .msg_seen_i(msg_q),
    .err_o     (chk_err),
    .is_msg_o  (chk_msg)
  );

  always_comb begin
    st_d    = st_q;
    pos_d   = pos_q;
    left_d  = left_q;
    reg_d   = reg_q;
    pad_d   = pad_q;
    msg_d   = msg_q;
    fin     = 1'b0;
    fin_err = E_OK;
    clr     = 1'b0;
    lo_we   = 1'b0;
    hi_we   = 1'b0;
    case (st_q)
      S_IDLE: if (start_i) begin
        clr   = 1'b1;
        msg_d = 1'b0;
        pos_d = '0;
        if (len_i[3:0] != 4'd0) begin
          fin = 1'b1; fin_err = E_LEN;
        end else if (len_i == '0) begin
          fin = 1'b1; fin_err = E_NOMSG;
        end else begin
          st_d = S_HDR;
        end
      end
      S_HDR: if (acc) begin
        pos_d = pos_q + 1'b1;
        if (w_type != PKT_REG && w_type != PKT_PAD) begin
          fin = 1'b1; fin_err = E_TYPE;
        end else if (need_end > {1'b0, len_q}) begin
          fin = 1'b1; fin_err = E_OVR;
        end else begin
          pad_d  = (w_type == PKT_PAD);
          left_d = {1'b0, w_cnt} + 15'd1;
          reg_d  = word_i[15:0];
          st_d   = S_BODY;
        end
      end
      S_BODY: if (acc) begin
        pos_d  = pos_q + 1'b1;
        left_d = left_q - 1'b1;
        reg_d  = reg_q + 1'b1;
        if (!pad_q) begin
          if (reg_q == REG_LO)       lo_we = 1'b1;
          else if (reg_q == REG_HI)  hi_we = 1'b1;
          else if (reg_q == REG_CMD) begin
            if (chk_err != E_OK) begin
              fin = 1'b1; fin_err = chk_err;
            end else if (chk_msg) begin
              msg_d = 1'b1;
            end
          end else if (reg_q != REG_CTL) begin
            fin = 1'b1; fin_err = E_REG;
          end
        end
        if (!fin && left_q == 15'd1) begin
          if ({1'b0, pos_q} + LW1'(1) == {1'b0, len_q}) begin
            fin     = 1'b1;
            fin_err = msg_d ? E_OK : E_NOMSG;
          end else begin
            st_d = S_HDR;
          end
        end
      end
      default: st_d = S_IDLE;
    endcase
    if (fin) st_d = S_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      len_q  <= '0;
      seg_q  <= '0;
      pos_q  <= '0;
      left_q <= '0;
      reg_q  <= '0;
      pad_q  <= 1'b0;
      msg_q  <= 1'b0;
      done_q <= 1'b0;
      pass_q <= 1'b0;
      err_q  <= E_OK;
    end else begin
      st_q   <= st_d;
      pos_q  <= pos_d;
      left_q <= left_d;
      reg_q  <= reg_d;
      pad_q  <= pad_d;
      msg_q  <= msg_d;
      done_q <= fin;
      if (st_q == S_IDLE && start_i) begin
        len_q <= len_i;
        seg_q <= seg_base_i;
      end
      if (fin) begin
        pass_q <= (fin_err == E_OK);
        err_q  <= fin_err;
      end
    end
  end

  assign done_o = done_q;
  assign pass_o = pass_q;
  assign err_o  = err_q;
endmodule

// File: rtl/cbv_validator_sva.sv
module cbv_validator_sva #(
  parameter int LEN_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [LEN_W-1:0] len_i,
  input logic             word_valid_i,
  input logic             word_ready_o,
  input logic             done_o,
  input logic             pass_o,
  input logic [3:0]       err_o
);
  logic [LEN_W-1:0] len_l;
  logic [LEN_W:0]   taken;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_l <= '0;
      taken <= '0;
    end else if (start_i && !word_ready_o) begin
      len_l <= len_i;
      taken <= '0;
    end else if (word_valid_i && word_ready_o) begin
      taken <= taken + 1'b1;
    end
  end

  a_r1_len_reject: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !word_ready_o && (len_i[3:0] != 4'd0)
      |=> done_o && !pass_o && (err_o == 4'd1));

  a_r4_within_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_i && word_ready_o |-> (taken < {1'b0, len_l}));

  a_r11_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_i |=> !done_o);

  a_r11_ready_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !word_ready_o);

  a_r11_result_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(err_o) && $stable(pass_o));
endmodule

bind cbv_validator cbv_validator_sva #(.LEN_W(LEN_W)) u_sva (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .len_i       (len_i),
  .word_valid_i(word_valid_i),
  .word_ready_o(word_ready_o),
  .done_o      (done_o),
  .pass_o      (pass_o),
  .err_o       (err_o)
);

// File: tb/cbv_validator_tb.sv
module cbv_validator_tb;
  localparam int ADDR_W = 40;
  localparam int IDX_W  = 8;
  localparam int LEN_W  = 16;
  localparam logic [15:0] R_LO = 16'h0100, R_HI = 16'h0101,
                          R_CMD = 16'h0102, R_CTL = 16'h0103;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              start_i = 1'b0;
  logic [LEN_W-1:0]  len_i = '0;
  logic [ADDR_W-1:0] seg_base_i = 40'h00_1000_0000;
  logic [IDX_W:0]    reloc_len_i = 9'd4;
  logic              word_valid_i = 1'b0;
  logic [31:0]       word_i = '0;
  logic              word_ready_o;
  logic [IDX_W-1:0]  reloc_idx_o;
  logic [ADDR_W-1:0] reloc_base_i, reloc_size_i;
  logic              done_o, pass_o;
  logic [3:0]        err_o;

  int n_chk = 0, n_bad = 0;
  logic [31:0] mem [0:63];
  int nw = 0;

  always #4 clk = ~clk;

  // relocation table: 0 seg1 1MB, 1 seg2 64MB, 2 crosses 0x20000000, 3 seg1 4KB
  always_comb begin
    case (reloc_idx_o)
      8'd0:    begin reloc_base_i = 40'h00_1000_0000; reloc_size_i = 40'h00_0010_0000; end
      8'd1:    begin reloc_base_i = 40'h00_2000_0000; reloc_size_i = 40'h00_0400_0000; end
      8'd2:    begin reloc_base_i = 40'h00_1FFF_F000; reloc_size_i = 40'h00_0000_2000; end
      8'd3:    begin reloc_base_i = 40'h00_1020_0000; reloc_size_i = 40'h00_0000_1000; end
      default: begin reloc_base_i = '0; reloc_size_i = '0; end
    endcase
  end

  cbv_validator u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .len_i(len_i),
    .seg_base_i(seg_base_i), .reloc_len_i(reloc_len_i),
    .word_valid_i(word_valid_i), .word_i(word_i), .word_ready_o(word_ready_o),
    .reloc_idx_o(reloc_idx_o), .reloc_base_i(reloc_base_i),
    .reloc_size_i(reloc_size_i), .done_o(done_o), .pass_o(pass_o), .err_o(err_o)
  );

  function automatic logic [31:0] hdr(input logic [1:0] t, input int cnt,
                                      input logic [15:0] r);
    return {t, cnt[13:0], r};
  endfunction

  task automatic put(input logic [31:0] w);
    mem[nw] = w;
    nw++;
  endtask

  task automatic cmd(input int code, input int idx, input int off);
    put(hdr(2'd0, 2, R_LO));
    put(off);
    put(idx);
    put(code << 1);
  endtask

  task automatic pad(input int n);
    put(hdr(2'd2, n - 2, 16'h0));
    for (int i = 1; i < n; i++) put(32'h0);
  endtask

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic run_buf(input string r, input int len, input logic [3:0] exp);
    int k = 0;
    int guard = 0;
    bit got = 0;
    logic [3:0] e = 4'hF;
    logic p = 1'b0;
    @(negedge clk);
    start_i = 1'b1;
    len_i = len[LEN_W-1:0];
    @(negedge clk);
    start_i = 1'b0;
    while (!got && guard < 2000) begin
      if (done_o) begin
        got = 1; e = err_o; p = pass_o;
      end else begin
        word_valid_i = (k < nw);
        if (k < nw) word_i = mem[k];
        #1;
        if (word_valid_i && word_ready_o) k++;
        @(negedge clk);
        guard++;
      end
    end
    word_valid_i = 1'b0;
    chk({r, " err"}, 32'(e), 32'(exp));
    chk({r, " pass"}, 32'(p), 32'(exp == 4'd0));
    chk({r, " ready low after done"}, 32'(word_ready_o), 32'd0);
    nw = 0;
  endtask

  task automatic t_reset();
    chk("R11 reset done", 32'(done_o), 0);
    chk("R11 reset ready", 32'(word_ready_o), 0);
    chk("R11 reset err", 32'(err_o), 0);
  endtask

  task automatic t_clean();
    cmd(0, 0, 0); cmd(1, 1, 0); pad(8);
    run_buf("R6 R10 clean msg+code1", 16, 4'd0);
    put(hdr(2'd0, 3, R_LO)); put(0); put(0); put(0); put(32'hDEAD); pad(11);
    run_buf("R2 R3 multi-reg packet with ctrl", 16, 4'd0);
    put(hdr(2'd0, 0, R_CTL)); put(32'h5); cmd(0, 0, 0); pad(10);
    run_buf("R3 ctrl write ignored", 16, 4'd0);
    cmd(0, 0, 0); cmd(1, 1, 0); cmd(3, 0, 32'h100); pad(20);
    run_buf("R9 code3 in seg, 32 words", 32, 4'd0);
    cmd(0, 0, 0); cmd(32'h100, 1, 0); pad(8);
    run_buf("R6 code 0x100 no size check", 16, 4'd0);
  endtask

  task automatic t_length();
    run_buf("R1 len 20", 20, 4'd1);
    run_buf("R10 len 0 no msg", 0, 4'd13);
    put(hdr(2'd2, 20, 16'h0));
    run_buf("R4 packet overrun", 16, 4'd4);
  endtask

  task automatic t_packets();
    put(hdr(2'd1, 0, 16'h0));
    run_buf("R2 type1 rejected", 16, 4'd2);
    put(hdr(2'd0, 0, 16'h0104)); put(32'h1);
    run_buf("R3 bad register", 16, 4'd3);
  endtask

  task automatic t_ranges();
    cmd(0, 7, 0);
    run_buf("R5 index out of table", 16, 4'd5);
    cmd(0, 0, 0); cmd(5, 1, 0);
    run_buf("R6 bad code", 16, 4'd6);
    cmd(0, 3, 32'h1000);
    run_buf("R7 end not above start", 16, 4'd7);
    cmd(0, 3, 32'hC00);
    run_buf("R7 msg too small", 16, 4'd8);
    cmd(0, 0, 0); cmd(1, 0, 0);
    run_buf("R7 code1 below 32MiB", 16, 4'd8);
    cmd(0, 0, 0); cmd(32'h100, 2, 0);
    run_buf("R8 crosses 256MB", 16, 4'd9);
    cmd(0, 1, 0);
    run_buf("R9 msg out of segment", 16, 4'd10);
    cmd(0, 0, 0); cmd(3, 1, 0);
    run_buf("R9 code3 out of segment", 16, 4'd10);
  endtask

  task automatic t_order();
    cmd(0, 0, 0); cmd(0, 0, 0);
    run_buf("R10 second message", 16, 4'd11);
    cmd(2, 1, 0);
    run_buf("R10 command before message", 16, 4'd12);
    pad(16);
    run_buf("R10 no message", 16, 4'd13);
  endtask

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog R11 actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_clean();
    t_length();
    t_packets();
    t_ranges();
    t_order();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule